// File: doc/BRIEF.md
# Tone-Envelope Command Transmitter for Satellite Switch Control

This block serialises a short control message, held by the host in a byte buffer, into the on/off envelope of a 22 kHz signalling tone on one output line. The line is high while the tone should sound. Each bit is sent as a high interval followed by a low interval. The split between the two intervals encodes the bit value. Each byte is sent most significant bit first and is followed by a parity bit. The message is framed by quiet gaps. After the message, the host may ask for one of two kinds of burst: a plain unmodulated tone, or an all-ones data byte.

The host loads the buffer and sets the byte count and burst choice. It then pulses `start`. The block asserts `busy`, reads bytes through a combinational read port (`rd_addr` out, `rd_data` in), and pulses `done` when the sequence is over. A prescaler derives a tick from the system clock, and every duration counts in those ticks. The default tick is 1 us at 50 MHz. If the carrier option is enabled, a second output gives the envelope gated by a 22 kHz square wave that is generated from the same clock.

Top module: `diseqc_tx`

## Requirements
- R1: After reset, `env`, `carrier`, `busy` and `done` are all low. `env` is low whenever `busy` is low.
- R2: A start accepted from idle raises `busy` at the next edge. The line then stays low for `T_GAP` ticks before any bit is sent.
- R3: A logic 1 bit is `T_SHORT` ticks high followed by `T_LONG` ticks low. A logic 0 bit is `T_LONG` ticks high followed by `T_SHORT` ticks low. One tick is `TICK_DIV` clock cycles.
- R4: Each byte goes out bit 7 first, down to bit 0.
- R5: After the eight data bits, a ninth bit is sent. It equals 1 XOR all eight data bits, which gives odd parity over nine bits.
- R6: After the last message byte, the line stays low for `T_GAP` ticks.
- R7: With `burst_sel` = 1 (tone burst), the line is then held high for `T_TONE` ticks and returns low.
- R8: With `burst_sel` = 2 (data burst), the byte 0xFF is sent with the normal bit encoding and its parity bit, which is 1.
- R9: After either burst, the line stays low for a further `T_SETTLE` ticks before the sequence ends. With `burst_sel` = 0 or 3, the sequence ends right after the trailing gap.
- R10: A byte count of zero is legal. It produces only the two gaps, followed by whatever burst was selected.
- R11: A `start` pulse while `busy` is high has no effect on the waveform in progress.
- R12: `done` is high for exactly one cycle. That cycle is the first one in which `busy` is low after a sequence.
- R13: `carrier` equals `env` ANDed with a square wave whose half period is `CAR_HALF` clocks. It is never high while `env` is low.
- R14: `rd_addr` gives the index of the byte being sent, from 0 upwards. A byte count above `MAX_BYTES` is clamped to `MAX_BYTES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, sampled only when idle |
| num_bytes | input | $clog2(MAX_BYTES+1) | Message length in bytes |
| burst_sel | input | 2 | 0 none, 1 tone burst, 2 data burst, 3 none |
| rd_addr | output | max(1,$clog2(MAX_BYTES)) | Byte buffer read address |
| rd_data | input | 8 | Byte buffer read data (combinational) |
| env | output | 1 | Tone envelope, high while the tone is on |
| carrier | output | 1 | Envelope gated with the 22 kHz square wave |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench sweeps message lengths from zero up to beyond the buffer size, against every burst choice and against bytes that mix ones and zeros. It compares the run lengths of the whole envelope with a waveform computed arithmetically. If the asymmetric high/low split were swapped, or the bits went out LSB first, or the parity started from 0, the run lengths would come out in the wrong places. A missing settle wait, or one added after a no-burst sequence, shows up as `done` arriving early or late. A re-triggered start during a message would corrupt the run list. A carrier that leaks while the envelope is low is counted cycle by cycle.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
   typedef enum logic [1:0] {
      BURST_NONE = 2'd0,
      BURST_TONE = 2'd1,
      BURST_DATA = 2'd2,
      BURST_NIL  = 2'd3
   } burst_e;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_PRE    = 3'd1,
      S_BIT_HI = 3'd2,
      S_BIT_LO = 3'd3,
      S_POST   = 3'd4,
      S_TONE   = 3'd5,
      S_SETTLE = 3'd6
   } seq_state_e;
endpackage

// File: rtl/dsq_tick.sv
module dsq_tick #(
   parameter int TICK_DIV = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

   initial begin
      assert (TICK_DIV >= 1) else $error("TICK_DIV must be at least 1");
   end

   generate
      if (TICK_DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         logic [DW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt <= '0;
            else if (clr)                        cnt <= '0;
            else if (cnt == DW'(TICK_DIV - 1))   cnt <= '0;
            else                                 cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == DW'(TICK_DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/dsq_carrier.sv
module dsq_carrier #(
   parameter bit HAS_CARRIER = 1'b1,
   parameter int CAR_HALF    = 1136
) (
   input  logic clk,
   input  logic rst_n,
   input  logic env,
   output logic carrier
);
   localparam int CW = (CAR_HALF > 1) ? $clog2(CAR_HALF) : 1;

   initial begin
      assert (CAR_HALF >= 1) else $error("CAR_HALF must be at least 1");
   end

   generate
      if (HAS_CARRIER) begin : g_car
         logic [CW-1:0] cnt;
         logic          sq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
               sq  <= 1'b0;
            end else if (cnt == CW'(CAR_HALF - 1)) begin
               cnt <= '0;
               sq  <= ~sq;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign carrier = env & sq;
      end else begin : g_nocar
         assign carrier = 1'b0;
      end
   endgenerate

   p_carrier_gated_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !env |-> !carrier);
endmodule

// File: rtl/dsq_seq.sv
module dsq_seq
   import dsq_pkg::*;
#(
   parameter int MAX_BYTES = 16,
   parameter int T_SHORT   = 500,
   parameter int T_LONG    = 1000,
   parameter int T_GAP     = 16000,
   parameter int T_TONE    = 12500,
   parameter int T_SETTLE  = 20000,
   localparam int CNT_W    = $clog2(MAX_BYTES + 1),
   localparam int AW       = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start,
   input  logic [CNT_W-1:0] num_bytes,
   input  logic [1:0]       burst_sel,
   output logic [AW-1:0]    rd_addr,
   input  logic [7:0]       rd_data,
   output logic             accept,
   output logic             env,
   output logic             busy,
   output logic             done
);
   localparam int M1   = (T_SHORT > T_LONG)  ? T_SHORT : T_LONG;
   localparam int M2   = (T_GAP   > T_TONE)  ? T_GAP   : T_TONE;
   localparam int M3   = (M1 > M2) ? M1 : M2;
   localparam int MAXT = (M3 > T_SETTLE) ? M3 : T_SETTLE;
   localparam int TW   = $clog2(MAXT + 1);

   initial begin
      assert (MAX_BYTES >= 1) else $error("MAX_BYTES must be at least 1");
      assert (T_SHORT >= 1 && T_LONG >= 1 && T_GAP >= 1 && T_TONE >= 1 && T_SETTLE >= 1)
         else $error("all durations must be at least one tick");
   end

   seq_state_e       state;
   logic [TW-1:0]    elapsed;
   logic [TW-1:0]    target;
   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] byte_idx;
   logic [3:0]       bit_idx;
   logic [1:0]       burst_q;
   logic             in_burst;
   logic [7:0]       cur_byte;
   logic             cur_bit;
   logic             phase_end;

   assign accept   = (state == S_IDLE) && start;
   assign cur_byte = in_burst ? 8'hFF : rd_data;
   assign cur_bit  = (bit_idx == 4'd8) ? ~^cur_byte : cur_byte[3'd7 - bit_idx[2:0]];
   assign rd_addr  = AW'(byte_idx);

   always_comb begin
      case (state)
         S_PRE, S_POST: target = TW'(T_GAP);
         S_BIT_HI:      target = cur_bit ? TW'(T_SHORT) : TW'(T_LONG);
         S_BIT_LO:      target = cur_bit ? TW'(T_LONG)  : TW'(T_SHORT);
         S_TONE:        target = TW'(T_TONE);
         S_SETTLE:      target = TW'(T_SETTLE);
         default:       target = TW'(1);
      endcase
   end

   assign phase_end = tick && (state != S_IDLE) && (elapsed == target - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         elapsed  <= '0;
         len_q    <= '0;
         byte_idx <= '0;
         bit_idx  <= '0;
         burst_q  <= BURST_NONE;
         in_burst <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            state    <= S_PRE;
            elapsed  <= '0;
            len_q    <= (num_bytes > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : num_bytes;
            burst_q  <= burst_sel;
            byte_idx <= '0;
            bit_idx  <= '0;
            in_burst <= 1'b0;
         end else if (phase_end) begin
            elapsed <= '0;
            case (state)
               S_PRE:    state <= (len_q != '0) ? S_BIT_HI : S_POST;
               S_BIT_HI: state <= S_BIT_LO;
               S_BIT_LO: begin
                  if (bit_idx != 4'd8) begin
                     bit_idx <= bit_idx + 1'b1;
                     state   <= S_BIT_HI;
                  end else begin
                     bit_idx <= '0;
                     if (in_burst) begin
                        state <= S_SETTLE;
                     end else if (byte_idx + 1'b1 < len_q) begin
                        byte_idx <= byte_idx + 1'b1;
                        state    <= S_BIT_HI;
                     end else begin
                        state <= S_POST;
                     end
                  end
               end
               S_POST: begin
                  if (burst_q == BURST_TONE) begin
                     state <= S_TONE;
                  end else if (burst_q == BURST_DATA) begin
                     in_burst <= 1'b1;
                     bit_idx  <= '0;
                     state    <= S_BIT_HI;
                  end else begin
                     state <= S_IDLE;
                     done  <= 1'b1;
                  end
               end
               S_TONE:   state <= S_SETTLE;
               S_SETTLE: begin
                  state <= S_IDLE;
                  done  <= 1'b1;
               end
               default:  state <= S_IDLE;
            endcase
         end else if (tick && state != S_IDLE) begin
            elapsed <= elapsed + 1'b1;
         end
      end
   end

   assign busy = (state != S_IDLE);
   assign env  = (state == S_BIT_HI) || (state == S_TONE);

   p_idle_env_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !env);
   p_done_after_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (len_q == $past(len_q) && burst_q == $past(burst_q)));
   p_bit_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bit_idx <= 4'd8));
   p_addr_range_r14: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (byte_idx < CNT_W'(MAX_BYTES)));
   p_elapsed_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (elapsed < target));
endmodule

// File: rtl/diseqc_tx.sv
module diseqc_tx
   import dsq_pkg::*;
#(
   parameter int MAX_BYTES   = 16,
   parameter int TICK_DIV    = 50,
   parameter int T_SHORT     = 500,
   parameter int T_LONG      = 1000,
   parameter int T_GAP       = 16000,
   parameter int T_TONE      = 12500,
   parameter int T_SETTLE    = 20000,
   parameter bit HAS_CARRIER = 1'b1,
   parameter int CAR_HALF    = 1136,
   localparam int CNT_W      = $clog2(MAX_BYTES + 1),
   localparam int AW         = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] num_bytes,
   input  logic [1:0]       burst_sel,
   output logic [AW-1:0]    rd_addr,
   input  logic [7:0]       rd_data,
   output logic             env,
   output logic             carrier,
   output logic             busy,
   output logic             done
);
   logic tick;
   logic accept;

   dsq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .tick  (tick)
   );

   dsq_seq #(
      .MAX_BYTES (MAX_BYTES),
      .T_SHORT   (T_SHORT),
      .T_LONG    (T_LONG),
      .T_GAP     (T_GAP),
      .T_TONE    (T_TONE),
      .T_SETTLE  (T_SETTLE)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .start     (start),
      .num_bytes (num_bytes),
      .burst_sel (burst_sel),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .accept    (accept),
      .env       (env),
      .busy      (busy),
      .done      (done)
   );

   dsq_carrier #(.HAS_CARRIER(HAS_CARRIER), .CAR_HALF(CAR_HALF)) u_car (
      .clk     (clk),
      .rst_n   (rst_n),
      .env     (env),
      .carrier (carrier)
   );
endmodule

// File: tb/tb_diseqc_tx.sv
module tb_diseqc_tx;
   localparam int MAXB = 16;
   localparam int DIV  = 2;
   localparam int TS   = 3;
   localparam int TL   = 6;
   localparam int TG   = 10;
   localparam int TT   = 8;
   localparam int TST  = 12;
   localparam int CH   = 3;
   localparam int CW   = $clog2(MAXB + 1);
   localparam int AW   = $clog2(MAXB);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] num_bytes = '0;
   logic [1:0]    burst_sel = 2'd0;
   logic [AW-1:0] rd_addr;
   logic [7:0]    rd_data;
   logic          env, carrier, busy, done;
   logic [7:0]    mem [MAXB];

   int checks = 0;
   int errors = 0;
   int carr_leak = 0;
   int carr_hi = 0;
   int exp_lvl [600];
   int exp_len [600];
   int n_exp;
   int got_lvl [600];
   int got_len [600];
   int n_got;

   always #10 clk = ~clk;

   assign rd_data = mem[rd_addr];

   diseqc_tx #(
      .MAX_BYTES(MAXB), .TICK_DIV(DIV), .T_SHORT(TS), .T_LONG(TL),
      .T_GAP(TG), .T_TONE(TT), .T_SETTLE(TST), .HAS_CARRIER(1'b1), .CAR_HALF(CH)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .num_bytes(num_bytes),
      .burst_sel(burst_sel), .rd_addr(rd_addr), .rd_data(rd_data),
      .env(env), .carrier(carrier), .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic add_seg(input int lvl, input int ticks);
      if (n_exp > 0 && exp_lvl[n_exp-1] == lvl) exp_len[n_exp-1] += ticks * DIV;
      else begin
         exp_lvl[n_exp] = lvl;
         exp_len[n_exp] = ticks * DIV;
         n_exp++;
      end
   endtask

   // R3 bit shape, R4 MSB first, R5 parity
   task automatic add_byte(input logic [7:0] b);
      int par = 1;
      for (int i = 7; i >= 0; i--) begin
         int d = b[i];
         par ^= d;
         add_seg(1, d ? TS : TL);
         add_seg(0, d ? TL : TS);
      end
      add_seg(1, par ? TS : TL);
      add_seg(0, par ? TL : TS);
   endtask

   task automatic run_msg(input int len, input int bs, input bit poke, input string tag);
      int eff = (len > MAXB) ? MAXB : len;
      int cyc = 0;
      bit same = 1'b1;
      n_exp = 0;
      add_seg(0, TG);                             // R2
      for (int b = 0; b < eff; b++) add_byte(mem[b]); // R14 byte order
      add_seg(0, TG);                             // R6
      if (bs == 1) begin add_seg(1, TT); add_seg(0, TST); end   // R7 R9
      if (bs == 2) begin add_byte(8'hFF); add_seg(0, TST); end  // R8 R9

      @(negedge clk);
      num_bytes = CW'(len);
      burst_sel = 2'(bs);
      start     = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, {tag, " R2 busy after start"}, busy, 1);
      n_got = 0;
      while (busy && cyc < 20000) begin
         if (n_got > 0 && got_lvl[n_got-1] == int'(env)) got_len[n_got-1]++;
         else if (n_got < 600) begin
            got_lvl[n_got] = int'(env);
            got_len[n_got] = 1;
            n_got++;
         end
         if (!env && carrier) carr_leak++;
         if (env && carrier) carr_hi++;
         // R11: a second start mid-sequence must change nothing
         if (poke && (cyc == 30 || cyc == 31)) begin
            start = 1'b1; num_bytes = CW'(3); burst_sel = 2'd1;
         end else start = 1'b0;
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      if (n_got != n_exp) same = 1'b0;
      else for (int k = 0; k < n_exp; k++)
         if (got_lvl[k] != exp_lvl[k] || got_len[k] != exp_len[k]) same = 1'b0;
      check(n_got == n_exp, {tag, " waveform run count"}, n_got, n_exp);
      check(same, {tag, " waveform run lengths"}, same, 1);
      check(done == 1'b1, {tag, " R12 done at busy fall"}, done, 1);
      check(env == 1'b0, {tag, " R1 env low when idle"}, env, 0);
      @(negedge clk);
      check(done == 1'b0, {tag, " R12 done single cycle"}, done, 0);
   endtask

   initial begin
      #3000000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < MAXB; i++) mem[i] = 8'((i * 37 + 11) ^ (i << 4));
      mem[0] = 8'hE2; mem[1] = 8'h10; mem[2] = 8'h38; mem[3] = 8'h00;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(env == 0, "R1 env in reset", env, 0);
      check(busy == 0, "R1 busy in reset", busy, 0);
      check(done == 0, "R1 done in reset", done, 0);
      check(carrier == 0, "R1 carrier in reset", carrier, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R10 zero length, every burst code
      for (int bs = 0; bs < 4; bs++) run_msg(0, bs, 1'b0, "R10 len0");
      // R3 R4 R5 lengths and bursts sweep
      for (int len = 1; len <= 4; len++)
         for (int bs = 0; bs < 3; bs++) run_msg(len, bs, 1'b0, "R3 R4 R5 sweep");
      mem[0] = 8'hFF; mem[1] = 8'h01; mem[2] = 8'h80;
      run_msg(3, 2, 1'b0, "R8 data burst");
      run_msg(2, 1, 1'b1, "R11 start while busy");
      run_msg(MAXB, 0, 1'b0, "R14 full buffer");
      run_msg(20, 1, 1'b0, "R14 clamp");
      // R13 carrier gating
      check(carr_leak == 0, "R13 carrier leak while env low", carr_leak, 0);
      check(carr_hi > 0, "R13 carrier active while env high", carr_hi, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule